// File: doc/BRIEF.md
# Block-Write Configuration Slave

This block is a two-wire serial slave that loads a small bank of 8-bit configuration registers. It knows one kind of transaction, the block write. After a START and a matching address byte with the write direction, the master sends a command byte, then a byte count, then the data bytes. The slave acknowledges the command and count bytes and otherwise leaves them alone. Each data byte goes to the next register, always starting from register 0. There is no way to pick a register index.

The bus pins are open-drain. The block takes the line levels as inputs and gives out active-high pull-low enables. Both lines pass through a synchronizer and are sampled on the system clock, and START and STOP are found from the sampled levels. The register bank drives a flat parallel bus that the surrounding logic reads all the time. The master may end with a STOP after any whole byte, and every byte written before that point stays.

Top module: `cfgw_slave`

## Requirements
- R1: After reset every register on `cfg_o` reads 0, and both `sda_oe` and `scl_oe` are low.
- R2: The address byte 0xD2 (7-bit address 0x69 with the write bit 0) is acknowledged. An acknowledge means `sda_oe` pulls SDA low for the whole high phase of the ninth SCL clock, and `sda_oe` only changes while SCL is low.
- R3: Any other address byte, including 0xD3 (the read bit set), gets no acknowledge. SDA then stays released for every later byte until the next START, and no register changes.
- R4: The first two bytes after the address (the command byte and the count byte) are acknowledged whatever their values, and neither one changes a register.
- R5: Data byte k of a transfer (k = 0, 1, ...) is stored in register k. Register k appears on `cfg_o[8k+7:8k]`.
- R6: A STOP after any complete data byte keeps every register written before it. Registers past that point keep their previous values.
- R7: A transfer that ends before the count byte has been acknowledged changes no register.
- R8: Data bytes at positions 6 and 7 (and any position of NUM_REGS or higher) are acknowledged but change no defined register.
- R9: Data bytes past the declared count, or past position 31, are acknowledged and discarded. A count of 0 writes nothing.
- R10: A repeated START restarts address matching, and the transfer that follows fills registers again from register 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| scl_oe | output | 1 | SCL pull-low enable (never asserted) |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | SDA pull-low enable, high while acknowledging |
| cfg_o | output | NUM_REGS*8 | Register bank contents, register k at bits 8k+7:8k |

## Verification
The bench aims at the points where the byte sequence branches. A design that counted the command or count byte as data would shift every register by one or two places. A STOP after only the address or the command byte must leave the bank untouched, and a slave that committed too early would be caught there. Bytes past the count, in the undefined slots 6 and 7, or after a wrong or read address are sent on purpose: a design that wrapped its index, stored out of range, or went on acknowledging after a mismatch would corrupt a register or pull SDA low. A repeated START in the middle of a transfer checks that the slave returns to register 0 and does not carry on with the index it had.

// File: rtl/cfgw_pkg.sv
package cfgw_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_CMD,
    ST_CNT,
    ST_DATA,
    ST_IGNORE
  } cfgw_state_e;
endpackage

// File: rtl/cfgw_sync.sv
// Multi-flop synchronizer for one asynchronous line; STAGES must be >= 2.
module cfgw_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk) begin
    if (rst) pipe <= {STAGES{RST_VAL}};
    else     pipe <= {pipe[STAGES-2:0], din};
  end

  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/cfgw_cond.sv
// Edge and bus-condition detector on synchronized SCL/SDA levels.
module cfgw_cond (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  logic scl_q, sda_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  =  scl_s & ~scl_q;
  assign scl_fall  = ~scl_s &  scl_q;
  // SDA moving while SCL stays high marks a bus condition
  assign start_det =  scl_s & scl_q &  sda_q & ~sda_s;
  assign stop_det  =  scl_s & scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/cfgw_regbank.sv
// Register bank with a single write port; out-of-range indices are dropped.
module cfgw_regbank import cfgw_pkg::*; #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 6
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [IDX_W-1:0]           wr_idx,
  input  logic [BYTE_W-1:0]          wr_data,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  localparam int SEL_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  logic [BYTE_W-1:0] regs [NUM_REGS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_REGS; i++) regs[i] <= '0;
    end else if (wr_en && (wr_idx < IDX_W'(NUM_REGS))) begin
      regs[wr_idx[SEL_W-1:0]] <= wr_data;
    end
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_flat
    assign cfg_o[g*BYTE_W +: BYTE_W] = regs[g];
  end
endmodule

// File: rtl/cfgw_slave.sv
// Block-write-only two-wire configuration slave.
module cfgw_slave import cfgw_pkg::*; #(
  parameter logic [6:0] SLV_ADDR    = 7'h69,
  parameter int         NUM_REGS    = 6,
  parameter int         MAX_BYTES   = 32,
  parameter int         SYNC_STAGES = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       scl_i,
  output logic                       scl_oe,
  input  logic                       sda_i,
  output logic                       sda_oe,
  output logic [NUM_REGS*BYTE_W-1:0] cfg_o
);
  localparam int IDX_W = $clog2(MAX_BYTES + 1);
  localparam logic [BYTE_W-1:0] ADDR_WR  = {SLV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] MAX_B8   = BYTE_W'(MAX_BYTES);
  localparam logic [3:0]        BIT_LAST = 4'd8;  // eight bits shifted in
  localparam logic [3:0]        BIT_ACK  = 4'd9;  // inside the ack slot

  logic scl_s, sda_s;
  logic scl_rise, scl_fall, start_det, stop_det;

  cfgw_state_e       state;
  logic [3:0]        bit_cnt;
  logic [BYTE_W-1:0] shreg;
  logic [IDX_W-1:0]  byte_idx;
  logic [IDX_W-1:0]  byte_cnt;
  logic              wr_en;
  logic [IDX_W-1:0]  wr_idx;
  logic [BYTE_W-1:0] wr_data;
  logic [IDX_W-1:0]  cnt_clamped;

  cfgw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_scl (
    .clk(clk), .rst(rst), .din(scl_i), .dout(scl_s));
  cfgw_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sda (
    .clk(clk), .rst(rst), .din(sda_i), .dout(sda_s));

  cfgw_cond u_cond (
    .clk(clk), .rst(rst), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_det(start_det), .stop_det(stop_det));

  assign cnt_clamped = (shreg > MAX_B8) ? IDX_W'(MAX_BYTES) : IDX_W'(shreg);
  assign scl_oe      = 1'b0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      bit_cnt  <= '0;
      shreg    <= '0;
      sda_oe   <= 1'b0;
      byte_idx <= '0;
      byte_cnt <= '0;
      wr_en    <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_det) begin
        state    <= ST_ADDR;
        bit_cnt  <= '0;
        sda_oe   <= 1'b0;
        byte_idx <= '0;
      end else if (stop_det) begin
        state   <= ST_IDLE;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (state != ST_IDLE && state != ST_IGNORE) begin
        if (scl_rise && bit_cnt < BIT_LAST) begin
          shreg   <= {shreg[BYTE_W-2:0], sda_s};
          bit_cnt <= bit_cnt + 1'b1;
        end else if (scl_fall && bit_cnt == BIT_LAST) begin
          // byte complete: enter the ack slot
          bit_cnt <= BIT_ACK;
          sda_oe  <= 1'b1;
          case (state)
            ST_ADDR: begin
              if (shreg == ADDR_WR) begin
                state <= ST_CMD;
              end else begin
                state   <= ST_IGNORE;
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
              end
            end
            ST_CMD: state <= ST_CNT;
            ST_CNT: begin
              byte_cnt <= cnt_clamped;
              byte_idx <= '0;
              state    <= ST_DATA;
            end
            ST_DATA: begin
              if (byte_idx < byte_cnt) begin
                wr_en   <= 1'b1;
                wr_idx  <= byte_idx;
                wr_data <= shreg;
              end
              if (byte_idx < IDX_W'(MAX_BYTES)) byte_idx <= byte_idx + 1'b1;
            end
            default: ;
          endcase
        end else if (scl_fall && bit_cnt == BIT_ACK) begin
          sda_oe  <= 1'b0;
          bit_cnt <= '0;
        end
      end
    end
  end

  cfgw_regbank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .cfg_o(cfg_o));
endmodule

// File: rtl/cfgw_slave_chk.sv
module cfgw_slave_chk import cfgw_pkg::*; #(
  parameter int NUM_REGS = 6,
  parameter int IDX_W    = 6
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       scl_i,
  input logic                       sda_oe,
  input logic [NUM_REGS*BYTE_W-1:0] cfg_o,
  input cfgw_state_e                state,
  input logic                       wr_en,
  input logic [IDX_W-1:0]           wr_idx,
  input logic [IDX_W-1:0]           byte_cnt
);
  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (cfg_o == '0 && !sda_oe));

  p_ack_scl_low_r2: assert property (@(posedge clk) disable iff (rst)
    (sda_oe != $past(sda_oe)) |-> !scl_i);

  p_silent_ignore_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IGNORE) |-> !sda_oe);

  p_no_early_change_r7: assert property (@(posedge clk) disable iff (rst)
    (cfg_o != $past(cfg_o)) |-> ($past(state) == ST_DATA));

  p_count_bound_r9: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_idx < byte_cnt));
endmodule

bind cfgw_slave cfgw_slave_chk #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .scl_i(scl_i), .sda_oe(sda_oe), .cfg_o(cfg_o),
  .state(state), .wr_en(wr_en), .wr_idx(wr_idx), .byte_cnt(byte_cnt));

// File: tb/cfgw_slave_tb.sv
`timescale 1ns/1ps
module cfgw_slave_tb;
  localparam int NR   = 6;
  localparam int HALF = 12;
  localparam logic [7:0] ADDR_OK = 8'hD2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic scl_drv = 1'b1;
  logic sda_drv = 1'b1;
  logic scl_oe, sda_oe;
  logic scl_bus, sda_bus;
  logic [NR*8-1:0] cfg_o;

  int total = 0;
  int bad   = 0;
  logic [7:0] exp_regs [NR];
  logic [7:0] tx [40];

  always #2.5 clk = ~clk;

  assign scl_bus = scl_drv & ~scl_oe;
  assign sda_bus = sda_drv & ~sda_oe;

  cfgw_slave u_dut (
    .clk(clk), .rst(rst), .scl_i(scl_bus), .scl_oe(scl_oe),
    .sda_i(sda_bus), .sda_oe(sda_oe), .cfg_o(cfg_o));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [NR*8-1:0] exp_vec();
    logic [NR*8-1:0] v;
    for (int k = 0; k < NR; k++) v[k*8 +: 8] = exp_regs[k];
    return v;
  endfunction

  task automatic check_regs(input string tag);
    chk(cfg_o == exp_vec(), tag, longint'(cfg_o), longint'(exp_vec()));
  endtask

  task automatic bus_start();
    sda_drv = 1'b1; tick(HALF / 2);
    scl_drv = 1'b1; tick(HALF);
    sda_drv = 1'b0; tick(HALF);
    scl_drv = 1'b0; tick(HALF / 2);
  endtask

  task automatic bus_stop();
    sda_drv = 1'b0; tick(HALF / 2);
    scl_drv = 1'b1; tick(HALF);
    sda_drv = 1'b1; tick(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_drv = b[i]; tick(HALF / 2);
      scl_drv = 1'b1; tick(HALF);
      scl_drv = 1'b0; tick(HALF / 2);
    end
    sda_drv = 1'b1; tick(HALF / 2);
    scl_drv = 1'b1; tick(HALF / 2);
    ack = !sda_bus;
    tick(HALF / 2);
    scl_drv = 1'b0; tick(HALF / 2);
  endtask

  // nhead: how many of the command/count bytes are sent (0..2); data only when 2
  task automatic xfer(input logic [7:0] addr, input logic [7:0] cmd, input logic [7:0] cnt,
                      input int nhead, input int nsend, input bit do_stop, input string tag);
    bit ack;
    bit want;
    int nack_bad = 0;
    want = (addr == ADDR_OK);
    bus_start();
    send_byte(addr, ack);
    if (ack != want) nack_bad++;
    if (nhead > 0) begin send_byte(cmd, ack); if (ack != want) nack_bad++; end
    if (nhead > 1) begin
      send_byte(cnt, ack); if (ack != want) nack_bad++;
      for (int j = 0; j < nsend; j++) begin
        send_byte(tx[j], ack);
        if (ack != want) nack_bad++;
        if (want && j < int'(cnt) && j < 32 && j < NR) exp_regs[j] = tx[j];
      end
    end
    if (do_stop) bus_stop();
    chk(nack_bad == 0, {tag, " ack pattern"}, nack_bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL R5 watchdog actual=%0h expected=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int k = 0; k < NR; k++) exp_regs[k] = 8'h00;
    tick(5);
    rst = 1'b0;
    tick(3);
    // R1: reset state
    check_regs("R1 regs after reset");
    chk(sda_oe == 1'b0 && scl_oe == 1'b0, "R1 pull enables", {sda_oe, scl_oe}, 0);

    // R5, R2: full write of six bytes
    for (int j = 0; j < 40; j++) tx[j] = 8'(8'h11 * (j + 1));
    xfer(ADDR_OK, 8'h00, 8'd6, 2, 6, 1'b1, "R2 R5 full");
    check_regs("R5 sequential fill");

    // R3: wrong address and read bit, more bytes follow
    for (int j = 0; j < 40; j++) tx[j] = 8'hEE;
    xfer(8'hA4, 8'h00, 8'd6, 2, 6, 1'b1, "R3 wrong addr");
    check_regs("R3 wrong addr no change");
    xfer(8'hD3, 8'h00, 8'd6, 2, 6, 1'b1, "R3 read bit");
    check_regs("R3 read bit no change");

    // R7: abort before count acknowledged
    xfer(ADDR_OK, 8'h00, 8'd6, 0, 0, 1'b1, "R7 stop after addr");
    check_regs("R7 stop after addr");
    xfer(ADDR_OK, 8'h00, 8'd6, 1, 0, 1'b1, "R7 stop after cmd");
    check_regs("R7 stop after cmd");

    // R4: nonzero command byte, count used
    for (int j = 0; j < 40; j++) tx[j] = 8'(8'h30 + j);
    xfer(ADDR_OK, 8'hA5, 8'd6, 2, 6, 1'b1, "R4 cmd value");
    check_regs("R4 cmd ignored");

    // R6: stop after two of five data bytes
    for (int j = 0; j < 40; j++) tx[j] = 8'(8'hC0 + j);
    xfer(ADDR_OK, 8'h00, 8'd5, 2, 2, 1'b1, "R6 early stop");
    check_regs("R6 partial keep");

    // R8: bytes 6 and 7 acknowledged, defined regs unaffected beyond 0..5
    for (int j = 0; j < 40; j++) tx[j] = 8'(8'h5A ^ j);
    xfer(ADDR_OK, 8'h00, 8'd8, 2, 8, 1'b1, "R8 slots 6 7");
    check_regs("R8 undefined slots");

    // R9: extra bytes past count, and count 0
    for (int j = 0; j < 40; j++) tx[j] = 8'(8'h90 + j);
    xfer(ADDR_OK, 8'h00, 8'd2, 2, 5, 1'b1, "R9 past count");
    check_regs("R9 past count discarded");
    for (int j = 0; j < 40; j++) tx[j] = 8'h77;
    xfer(ADDR_OK, 8'h00, 8'd0, 2, 3, 1'b1, "R9 count zero");
    check_regs("R9 count zero");
    for (int j = 0; j < 40; j++) tx[j] = 8'(8'h40 + j);
    xfer(ADDR_OK, 8'h00, 8'd40, 2, 34, 1'b1, "R9 past 32");
    check_regs("R9 past 32 bytes");

    // R10: repeated start restarts at register 0
    for (int j = 0; j < 40; j++) tx[j] = 8'(8'hA0 + j);
    xfer(ADDR_OK, 8'h00, 8'd4, 2, 2, 1'b0, "R10 first part");
    for (int j = 0; j < 40; j++) tx[j] = 8'(8'hB0 + j);
    xfer(ADDR_OK, 8'h00, 8'd1, 2, 1, 1'b1, "R10 after rstart");
    check_regs("R10 restart from reg 0");

    // random mix
    for (int t = 0; t < 16; t++) begin
      logic [7:0] a, c, n;
      int ns;
      int nh;
      a = ADDR_OK;
      if ($urandom % 5 == 0) begin
        a = 8'($urandom);
        if (a == ADDR_OK) a = 8'hD3;
      end
      c  = 8'($urandom);
      n  = 8'($urandom % 41);
      ns = int'($urandom % 12);
      nh = ($urandom % 8 == 0) ? int'($urandom % 2) : 2;
      for (int j = 0; j < 40; j++) tx[j] = 8'($urandom);
      xfer(a, c, n, nh, ns, 1'b1, "R5 random");
      check_regs("R5 R9 random regs");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule